// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 56-bit physical address by walking a radix tree of translation tables that sit in memory. The tree has three levels. Each table holds 512 entries of 64 bits. The walk starts at the table whose page number sits in a translation control input. The block fetches one entry per level over a simple read port, checks each entry as it arrives, and returns either the translated address or a page-fault flag.

The block handles one translation at a time. A requester offers a virtual address and an access kind (read, write or execute). The walker drops its ready signal until the one-cycle response pulse has been given. When the translation-enable input is low, the walker skips the tree and returns the low 56 address bits unchanged, without touching memory.

Top module: `pgwalk_top`

## Requirements
- R1: On success, `rsp_paddr` equals the leaf entry's page number followed by the 12 low virtual address bits, which pass through unchanged.
- R2: Virtual address bits 63:39 have no effect on the walk or on the result.
- R3: Entry addresses are table page number times 4096 plus index times 8. The indices are used in this order: bits 38:30 at the root level, then bits 29:21, then bits 20:12. Exactly one read is issued for each level visited, and no request is accepted while a read is pending.
- R4: Entry format: bit 0 is valid, and bits 1, 2 and 3 are read, write and execute permission. Bits 53:10 hold the page number. A valid entry with all three permission bits clear points to the next table.
- R5: An entry with bit 0 clear ends the walk with a fault, whatever its other bits hold. A faulting response carries a zero address.
- R6: A pointer entry read at the last level gives a fault.
- R7: A leaf entry found at the root or middle level gives a fault, after a single read at that level.
- R8: The access code is 0 for read, 1 for write and 2 for execute. The leaf must have the matching permission bit set, or a fault is raised. Code 3 always faults.
- R9: Each accepted request yields exactly one single-cycle `rsp_valid` pulse. `req_ready` stays low from acceptance through that pulse.
- R10: With `ctl_en` low at acceptance, the response arrives one cycle later with `rsp_paddr` equal to `req_vaddr[55:0]`, no fault, and no memory read.
- R11: After reset, `req_ready` is high and `rsp_valid` and `mem_req_valid` are low.
- R12: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Translation enable; low selects identity mapping |
| ctl_root_ppn | input | 44 | Page number of the root table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Page fault flag, valid with rsp_valid |
| rsp_paddr | output | 56 | Physical address, zero on fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The walker is driven with addresses that resolve through a full three-level chain. These check that the page number and offset are joined correctly and that each permission kind is matched to its own bit. Further addresses stop at an invalid entry at each level, at a pointer in the last table, and at a leaf in the root table. Each of these is told apart by its fault and by the exact number of reads and their addresses. An address with all upper bits set must translate like its clean twin. An identity pass with translation off, and a walk held back by a stalled memory port, check the bypass and the request hold behaviour.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int VA_W    = 39;
    localparam int PA_W    = 56;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 9;
    localparam int LEVELS  = 3;
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int PTE_W   = 64;
    localparam int PPN_LSB = 10;
    localparam int ENT_SH  = 3;
    localparam int VPN_W   = IDX_W * LEVELS;
    localparam int LVL_W   = $clog2(LEVELS);

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        CLS_FAULT,
        CLS_NEXT,
        CLS_LEAF
    } ent_cls_e;

    typedef struct packed {
        logic             vld;
        logic             rd;
        logic             wr;
        logic             ex;
        logic [PPN_W-1:0] ppn;
    } ent_fields_t;

    function automatic ent_fields_t ent_unpack(input logic [PTE_W-1:0] raw);
        ent_fields_t f;
        f.vld = raw[0];
        f.rd  = raw[1];
        f.wr  = raw[2];
        f.ex  = raw[3];
        f.ppn = raw[PPN_LSB +: PPN_W];
        return f;
    endfunction

    function automatic logic acc_allowed(input ent_fields_t f, input logic [1:0] acc);
        case (acc)
            ACC_READ:  return f.rd;
            ACC_WRITE: return f.wr;
            ACC_EXEC:  return f.ex;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
(
    input  logic [PPN_W-1:0] tbl_ppn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  ent_addr
);
    logic [IDX_W-1:0] idx_slice [LEVELS];
    logic [IDX_W-1:0] idx_sel;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_slice[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx_sel = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) idx_sel = idx_slice[i];
        end
    end

    assign ent_addr = {tbl_ppn, {OFF_W{1'b0}}}
                    + PA_W'({idx_sel, {ENT_SH{1'b0}}});
endmodule

// File: rtl/pgwalk_ent_check.sv
module pgwalk_ent_check
    import pgwalk_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    input  logic [1:0]       acc,
    input  logic             last_lvl,
    output ent_cls_e         cls,
    output logic [PPN_W-1:0] ppn
);
    ent_fields_t f;
    logic        is_leaf;

    assign f       = ent_unpack(raw);
    assign is_leaf = f.rd | f.wr | f.ex;
    assign ppn     = f.ppn;

    always_comb begin
        if (!f.vld)                    cls = CLS_FAULT;
        else if (!is_leaf)             cls = last_lvl ? CLS_FAULT : CLS_NEXT;
        else if (!last_lvl)            cls = CLS_FAULT;
        else if (acc_allowed(f, acc))  cls = CLS_LEAF;
        else                           cls = CLS_FAULT;
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_en,
    input  logic [43:0]      ctl_root_ppn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_vaddr,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [55:0]      rsp_paddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [55:0]      mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data
);
    walk_st_e         st;
    logic [LVL_W-1:0] lvl;
    logic [PPN_W-1:0] tbl_ppn;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       acc_q;
    logic             fault_q;
    logic [PA_W-1:0]  pa_q;
    ent_cls_e         cls;
    logic [PPN_W-1:0] ent_ppn;
    logic             accept;

    pgwalk_addr u_addr (
        .tbl_ppn  (tbl_ppn),
        .vpn      (vpn_q),
        .level    (lvl),
        .ent_addr (mem_req_addr)
    );

    pgwalk_ent_check u_check (
        .raw      (mem_rsp_data),
        .acc      (acc_q),
        .last_lvl (lvl == '0),
        .cls      (cls),
        .ppn      (ent_ppn)
    );

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_ISSUE);
    assign rsp_valid     = (st == ST_RESP);
    assign rsp_fault     = fault_q;
    assign rsp_paddr     = pa_q;
    assign accept        = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            lvl     <= '0;
            tbl_ppn <= '0;
            vpn_q   <= '0;
            off_q   <= '0;
            acc_q   <= '0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    vpn_q   <= req_vaddr[OFF_W +: VPN_W];
                    off_q   <= req_vaddr[OFF_W-1:0];
                    acc_q   <= req_acc;
                    lvl     <= LVL_W'(LEVELS - 1);
                    tbl_ppn <= ctl_root_ppn;
                    fault_q <= 1'b0;
                    if (ctl_en) begin
                        st <= ST_ISSUE;
                    end else begin
                        pa_q <= req_vaddr[PA_W-1:0];
                        st   <= ST_RESP;
                    end
                end
                ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    case (cls)
                        CLS_NEXT: begin
                            tbl_ppn <= ent_ppn;
                            lvl     <= lvl - 1'b1;
                            st      <= ST_ISSUE;
                        end
                        CLS_LEAF: begin
                            pa_q <= {ent_ppn, off_q};
                            st   <= ST_RESP;
                        end
                        default: begin
                            fault_q <= 1'b1;
                            pa_q    <= '0;
                            st      <= ST_RESP;
                        end
                    endcase
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgwalk_checker.sv
module pgwalk_checker (
    input logic        clk,
    input logic        rst,
    input logic        ctl_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_vaddr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [55:0] rsp_paddr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [55:0] mem_req_addr
);
    logic [11:0] off_seen;

    always_ff @(posedge clk) begin
        if (rst) off_seen <= '0;
        else if (req_valid && req_ready) off_seen <= req_vaddr[11:0];
    end

    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r3_no_accept_while_reading: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r9_busy_at_response: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !ctl_en |=>
            rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr[55:0]));

    a_r5_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);

    a_r1_offset: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == off_seen);
endmodule

bind pgwalk_top pgwalk_checker u_pgwalk_chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_en        (ctl_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_en = 1'b1;
    logic [43:0] ctl_root_ppn = 44'h100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid, rsp_fault;
    logic [55:0] rsp_paddr;
    logic        mem_req_valid;
    logic        mem_rdy = 1'b1;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int nreads = 0;
    int cycles = 0;
    logic [55:0] addr_log [0:255];
    logic [63:0] pmem [logic [55:0]];

    always #2 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_root_ppn(ctl_root_ppn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_rdy), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid && mem_rdy;
        if (mem_req_valid && mem_rdy) begin
            mem_rsp_data <= pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 64'd0;
            addr_log[nreads[7:0]] <= mem_req_addr;
            nreads <= nreads + 1;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    function automatic logic [55:0] ent_pa(input logic [43:0] ppn, input int idx);
        return {ppn, 12'h000} + 56'(idx * 8);
    endfunction

    function automatic logic [63:0] mk_ent(input logic [43:0] ppn, input logic [3:0] flg);
        return {10'd0, ppn, 6'd0, flg};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic        got_fault;
    logic [55:0] got_pa;
    int          rd_start;

    task automatic translate(input logic [63:0] va, input logic [1:0] acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        rd_start  = nreads;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 200; w++) begin
            if (rsp_valid) break;
            @(negedge clk);
        end
        got_fault = rsp_fault;
        got_pa    = rsp_paddr;
        chk(rsp_valid, "R9 response pulse", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 pulse ends and ready returns",
            {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    typedef struct packed {
        logic [24:0] hi;
        logic [8:0]  v2;
        logic [8:0]  v1;
        logic [8:0]  v0;
        logic [11:0] off;
        logic [1:0]  acc;
        logic        flt;
        logic [55:0] pa;
        logic [2:0]  nrd;
    } vec_t;

    // R1 R2 R4 R5 R6 R7 R8: leaf chains, invalid entries, wrong-level entries
    localparam vec_t VECS [13] = '{
        '{25'h0, 9'd1, 9'd2, 9'd3, 12'h123, 2'd0, 1'b0, 56'hABCDE123, 3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd3, 12'h123, 2'd1, 1'b0, 56'hABCDE123, 3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd3, 12'h123, 2'd2, 1'b1, 56'h0,        3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd4, 12'h456, 2'd2, 1'b0, 56'h12345456, 3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd4, 12'h456, 2'd0, 1'b1, 56'h0,        3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd5, 12'h000, 2'd0, 1'b1, 56'h0,        3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd6, 12'h000, 2'd0, 1'b1, 56'h0,        3'd3},
        '{25'h0, 9'd1, 9'd7, 9'd0, 12'h000, 2'd0, 1'b1, 56'h0,        3'd2},
        '{25'h0, 9'd3, 9'd0, 9'd0, 12'h000, 2'd0, 1'b1, 56'h0,        3'd1},
        '{25'h0, 9'd0, 9'd9, 9'd9, 12'h000, 2'd0, 1'b1, 56'h0,        3'd1},
        '{25'h1FFFFFF, 9'd1, 9'd2, 9'd3, 12'hFFF, 2'd0, 1'b0, 56'hABCDEFFF, 3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd3, 12'h010, 2'd3, 1'b1, 56'h0,        3'd3},
        '{25'h0, 9'd1, 9'd2, 9'd8, 12'h000, 2'd0, 1'b1, 56'h0,        3'd3}
    };

    initial begin
        pmem[ent_pa(44'h100, 1)] = mk_ent(44'h200,   4'b0001);
        pmem[ent_pa(44'h200, 2)] = mk_ent(44'h300,   4'b0001);
        pmem[ent_pa(44'h300, 3)] = mk_ent(44'hABCDE, 4'b0111);
        pmem[ent_pa(44'h300, 4)] = mk_ent(44'h12345, 4'b1001);
        pmem[ent_pa(44'h300, 6)] = mk_ent(44'h400,   4'b0001);
        pmem[ent_pa(44'h300, 8)] = mk_ent(44'h777,   4'b1110);
        pmem[ent_pa(44'h100, 3)] = mk_ent(44'h500,   4'b0011);

        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R11 reset state",
            {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
        rst = 1'b0;
        @(negedge clk);

        foreach (VECS[i]) begin
            translate({VECS[i].hi, VECS[i].v2, VECS[i].v1, VECS[i].v0, VECS[i].off}, VECS[i].acc);
            chk(got_fault == VECS[i].flt, $sformatf("R5/R6/R7/R8 fault vec %0d", i),
                {63'd0, got_fault}, {63'd0, VECS[i].flt});
            chk(got_pa == VECS[i].pa, $sformatf("R1/R2 paddr vec %0d", i),
                {8'd0, got_pa}, {8'd0, VECS[i].pa});
            chk(nreads - rd_start == int'(VECS[i].nrd), $sformatf("R3 read count vec %0d", i),
                64'(nreads - rd_start), {61'd0, VECS[i].nrd});
        end

        // R3: entry address sequence for a full walk
        translate({25'h0, 9'd1, 9'd2, 9'd3, 12'h0}, 2'd0);
        chk(addr_log[rd_start[7:0]] == 56'h100008, "R3 root entry address",
            {8'd0, addr_log[rd_start[7:0]]}, 64'h100008);
        chk(addr_log[8'(rd_start + 1)] == 56'h200010, "R3 middle entry address",
            {8'd0, addr_log[8'(rd_start + 1)]}, 64'h200010);
        chk(addr_log[8'(rd_start + 2)] == 56'h300018, "R3 last entry address",
            {8'd0, addr_log[8'(rd_start + 2)]}, 64'h300018);

        // R12: stalled memory port holds the request
        mem_rdy = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {25'h0, 9'd1, 9'd2, 9'd4, 12'h0};
        req_acc   = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == 56'h100008 && !req_ready, "R12 request held",
            {8'd0, mem_req_addr}, 64'h100008);
        mem_rdy = 1'b1;
        for (int w = 0; w < 50 && !rsp_valid; w++) @(negedge clk);
        chk(rsp_valid && !rsp_fault && rsp_paddr == 56'h12345000, "R12 completes after stall",
            {8'd0, rsp_paddr}, 64'h12345000);
        @(negedge clk);

        // R10: identity bypass
        ctl_en = 1'b0;
        translate(64'hFEDC_BA98_7654_3210, 2'd1);
        chk(!got_fault && got_pa == 56'hDC_BA98_7654_3210, "R10 identity address",
            {8'd0, got_pa}, 64'h00DC_BA98_7654_3210);
        chk(nreads == rd_start, "R10 no memory read", 64'(nreads - rd_start), 64'd0);
        ctl_en = 1'b1;

        finish_run();
    end
endmodule